// File: doc/BRIEF.md
# Reversible Four-Bit Counter with Asynchronous Preset

This block is a binary counter that steps up or down by one on each rising clock edge while its active-low enable is held low. Two asynchronous controls override counting. A master clear forces the state to zero. A level-sensitive preset makes the state follow the data inputs for as long as it is held high. When the preset is released, the last data value stays in the counter, and counting continues from that value on the next enabled edge. Both directions wrap around.

An active-low terminal flag goes low on the final code for the selected direction, but only while counting is enabled. The flag is combinational. To build a wider counter, connect the flag of one stage to the enable of the next stage and share the clock and direction. The next stage then steps on the same edge on which the lower stage wraps.

The width is a parameter and defaults to four bits. The state is held in one flip-flop cell per bit. Each cell has an asynchronous set and an asynchronous clear, derived from the preset and the data bit. This lets the outputs follow the data inputs while the preset is high.

Top module: `updn_load_counter`

## Requirements
- R1: While `rst_async` is high, `q` is all zeros. This holds immediately, whatever the other inputs are, including when `load` is high.
- R2: While `load` is high and `rst_async` is low, `q` equals `din` without waiting for a clock edge and follows changes of `din`. Clock edges, `cnt_en_n` and `up` have no effect during this time.
- R3: With `rst_async` and `load` low, `cnt_en_n` low and `up` high (1 = up), `q` increments by one on each rising `clk` edge.
- R4: With `rst_async` and `load` low, `cnt_en_n` low and `up` low (0 = down), `q` decrements by one on each rising `clk` edge.
- R5: With `cnt_en_n` high and both asynchronous controls low, `q` keeps its value through clock edges, for either value of `up`.
- R6: Counting up from the all-ones code gives zero. Counting down from zero gives the all-ones code.
- R7: `term_n` is low exactly when `cnt_en_n` is low and either `up` is 1 with `q` all ones, or `up` is 0 with `q` zero. Otherwise it is high.
- R8: `term_n` is combinational. A change of `cnt_en_n`, `up` or the state shows on `term_n` without a clock edge.
- R9: The priority order is clear over preset over counting over holding. When `load` falls, the counter keeps the last `din` and counts from it on the next enabled edge. When `rst_async` falls while `load` is high, `q` takes `din`.
- R10: Two instances that share the clock and direction, with the lower stage's `term_n` driving the upper stage's `cnt_en_n`, form a counter twice as wide. It steps and wraps correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst_async | input | 1 | Asynchronous clear, active high, highest priority |
| load | input | 1 | Asynchronous level-sensitive preset, active high |
| cnt_en_n | input | 1 | Count enable, active low; also gates `term_n` |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Preset data |
| q | output | WIDTH | Counter state |
| term_n | output | 1 | Terminal flag, active low, combinational |

## Verification
The hardest behaviour to reach from the ports is an asynchronous control that acts between two clock edges. This covers a preset or clear pulse that rises and falls inside one clock period, and a clear that is released while the preset is still high. In both cases the state must change and then hold with no edge involved. The directed stimulus applies these pulses at fixed offsets inside the high phase of the clock and samples the outputs before the next edge. It then checks the first count after the pulse. The cascade case chains two instances and presets them just below each wrap point, so that the lower stage's terminal flag has to enable the upper stage at both ends.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Mask of the low w bits of a 32-bit word.
  function automatic logic [31:0] low_mask(int unsigned w);
    if (w >= 32) return '1;
    return (32'd1 << w) - 32'd1;
  endfunction

  // One step in the given direction, wrapped to w bits.
  function automatic logic [31:0] step_wrap(logic [31:0] v, dir_e dir, int unsigned w);
    logic [31:0] r;
    if (dir == DIR_UP) r = v + 32'd1;
    else               r = v - 32'd1;
    return r & low_mask(w);
  endfunction

  // True when v is the last code before a wrap in the given direction.
  function automatic logic last_code(logic [31:0] v, dir_e dir, int unsigned w);
    if (dir == DIR_UP) return (v & low_mask(w)) == low_mask(w);
    return (v & low_mask(w)) == 32'd0;
  endfunction

endpackage

// File: rtl/updn_step.sv
// Synchronous next-state selection: step when enabled, otherwise hold.
module updn_step #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_i,
  input  logic             cnt_en_n_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             count_go_o
);
  import updn_pkg::*;

  dir_e             dir;
  logic [WIDTH-1:0] stepped;

  assign dir        = dir_e'(up_i);
  assign count_go_o = ~cnt_en_n_i;
  assign stepped    = WIDTH'(step_wrap(32'(cnt_i), dir, WIDTH));

  always_comb begin
    if (count_go_o) nxt_o = stepped;
    else            nxt_o = cnt_i;
  end
endmodule

// File: rtl/updn_async_ctl.sv
// Turns clear and preset into per-bit asynchronous set and clear strobes.
// Clear wins over preset, and the two strobes of a bit never overlap.
module updn_async_ctl #(
  parameter int WIDTH = 4
) (
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] set_o,
  output logic [WIDTH-1:0] clr_o
);
  logic preset_live;

  assign preset_live = load_i & ~rst_i;

  for (genvar b = 0; b < WIDTH; b++) begin : g_strobe
    assign set_o[b] = preset_live &  din_i[b];
    assign clr_o[b] = rst_i | (preset_live & ~din_i[b]);
  end
endmodule

// File: rtl/updn_bit_cell.sv
// One state bit: edge-triggered data with asynchronous clear and set.
module updn_bit_cell (
  input  logic clk,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/updn_terminal.sv
// Combinational terminal flag, gated by the count enable.
module updn_terminal #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_i,
  input  logic             cnt_en_n_i,
  output logic             at_end_o,
  output logic             term_n_o
);
  import updn_pkg::*;

  assign at_end_o = last_code(32'(cnt_i), dir_e'(up_i), WIDTH);
  assign term_n_o = ~(at_end_o & ~cnt_en_n_i);
endmodule

// File: rtl/updn_load_counter.sv
module updn_load_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_async,
  input  logic             load,
  input  logic             cnt_en_n,
  input  logic             up,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             term_n
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;
  logic [WIDTH-1:0] bit_set;
  logic [WIDTH-1:0] bit_clr;
  logic             count_go;
  logic             at_end;

  updn_step #(.WIDTH(WIDTH)) u_step (
    .cnt_i      (cnt_q),
    .up_i       (up),
    .cnt_en_n_i (cnt_en_n),
    .nxt_o      (cnt_nxt),
    .count_go_o (count_go)
  );

  updn_async_ctl #(.WIDTH(WIDTH)) u_ctl (
    .rst_i  (rst_async),
    .load_i (load),
    .din_i  (din),
    .set_o  (bit_set),
    .clr_o  (bit_clr)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_cell
    updn_bit_cell u_cell (
      .clk   (clk),
      .set_i (bit_set[b]),
      .clr_i (bit_clr[b]),
      .d_i   (cnt_nxt[b]),
      .q_o   (cnt_q[b])
    );
  end

  updn_terminal #(.WIDTH(WIDTH)) u_term (
    .cnt_i      (cnt_q),
    .up_i       (up),
    .cnt_en_n_i (cnt_en_n),
    .at_end_o   (at_end),
    .term_n_o   (term_n)
  );

  assign q = cnt_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_async,
  input logic             load,
  input logic             cnt_en_n,
  input logic             up,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             term_n,
  input logic             count_go,
  input logic             at_end
);
  import updn_pkg::*;

  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  // High when an asynchronous control was active at the previous edge
  // or was raised since then. Clocked checks are excused in that case.
  logic disturbed;
  always_ff @(posedge clk or posedge rst_async or posedge load) begin
    if (rst_async || load) disturbed <= 1'b1;
    else                   disturbed <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_async) begin
      a_r1_clear_dominates: assert (q == '0) else $error("clear not applied");
    end
    if (!rst_async && load) begin
      a_r2_preset_follows: assert (q == din) else $error("preset not transparent");
    end
    if (!term_n) begin
      a_r7_flag_low_only_at_end: assert (at_end && !cnt_en_n && (q == '0 || q == TOP))
        else $error("terminal flag low off the end code");
    end
  end

  a_r3_r4_step: assert property (@(posedge clk) disable iff (rst_async)
    (!load && !cnt_en_n) |=> (disturbed || load ||
      q == WIDTH'(step_wrap(32'($past(q)), dir_e'($past(up)), WIDTH))))
    else $error("count step wrong");

  a_r3_go_changes_state: assert property (@(posedge clk) disable iff (rst_async)
    (count_go && !load) |=> (disturbed || load || q != $past(q)))
    else $error("enabled edge left state unchanged");

  a_r5_hold: assert property (@(posedge clk) disable iff (rst_async)
    (!load && cnt_en_n) |=> (disturbed || load || $stable(q)))
    else $error("state moved while disabled");

  a_r6_wrap_up: assert property (@(posedge clk) disable iff (rst_async)
    (!load && !cnt_en_n && up && q == TOP) |=> (disturbed || load || q == '0))
    else $error("upward wrap wrong");

  a_r6_wrap_down: assert property (@(posedge clk) disable iff (rst_async)
    (!load && !cnt_en_n && !up && q == '0) |=> (disturbed || load || q == TOP))
    else $error("downward wrap wrong");
endmodule

bind updn_load_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_async (rst_async),
  .load      (load),
  .cnt_en_n  (cnt_en_n),
  .up        (up),
  .din       (din),
  .q         (q),
  .term_n    (term_n),
  .count_go  (count_go),
  .at_end    (at_end)
);

// File: tb/sim_updn_load_counter.sv
`timescale 1ns/100ps
module sim_updn_load_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, ld = 1'b0, en_n = 1'b1, up = 1'b1;
  logic [3:0] din = 4'h0;
  logic [3:0] q;
  logic       tc_n;

  updn_load_counter #(.WIDTH(4)) u0 (
    .clk(clk), .rst_async(rst), .load(ld), .cnt_en_n(en_n), .up(up),
    .din(din), .q(q), .term_n(tc_n)
  );

  // Two-stage chain for the cascade scenario
  logic       c_rst = 1'b1, c_ld = 1'b0, c_en_n = 1'b1, c_up = 1'b1;
  logic [7:0] c_din = 8'h00;
  logic [3:0] c_lo, c_hi;
  logic       c_link, c_tc_hi;

  updn_load_counter #(.WIDTH(4)) u_lo (
    .clk(clk), .rst_async(c_rst), .load(c_ld), .cnt_en_n(c_en_n), .up(c_up),
    .din(c_din[3:0]), .q(c_lo), .term_n(c_link)
  );
  updn_load_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .rst_async(c_rst), .load(c_ld), .cnt_en_n(c_link), .up(c_up),
    .din(c_din[7:4]), .q(c_hi), .term_n(c_tc_hi)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic preset(logic [3:0] v);
    ld = 1'b1; din = v; #0.4;
    ld = 1'b0; #0.4;
  endtask

  task automatic t_reset();
    rst = 1'b1; ld = 1'b1; din = 4'hC; en_n = 1'b0; up = 1'b1;
    #1 check("R1 clear beats preset", {4'h0, q}, 8'h00);
    tick();
    check("R1 clear held over edge", {4'h0, q}, 8'h00);
    check("R7 flag high at zero counting up", {7'h0, tc_n}, 8'h01);
    ld = 1'b0; en_n = 1'b1;
    tick();
    rst = 1'b0; #0.4;
    check("R1 released clear keeps zero", {4'h0, q}, 8'h00);
  endtask

  task automatic t_load();
    tick();
    ld = 1'b1; din = 4'h9; #0.4;
    check("R2 preset immediate", {4'h0, q}, 8'h09);
    din = 4'h5; #0.4;
    check("R2 preset follows data", {4'h0, q}, 8'h05);
    en_n = 1'b0; up = 1'b0;
    tick();
    check("R2 clock ignored during preset", {4'h0, q}, 8'h05);
    tick();
    check("R2 clock ignored again", {4'h0, q}, 8'h05);
    ld = 1'b0; #0.4;
    check("R9 value kept after preset", {4'h0, q}, 8'h05);
    tick();
    check("R9 counts from preset value", {4'h0, q}, 8'h04);
    en_n = 1'b1;
  endtask

  task automatic t_count_up();
    tick();
    preset(4'hD);
    up = 1'b1; en_n = 1'b0;
    tick(); check("R3 up step", {4'h0, q}, 8'h0E);
    tick(); check("R3 up step", {4'h0, q}, 8'h0F);
    tick(); check("R6 wrap up to zero", {4'h0, q}, 8'h00);
    tick(); check("R3 up after wrap", {4'h0, q}, 8'h01);
    en_n = 1'b1;
  endtask

  task automatic t_count_down();
    tick();
    preset(4'h2);
    up = 1'b0; en_n = 1'b0;
    tick(); check("R4 down step", {4'h0, q}, 8'h01);
    tick(); check("R4 down step", {4'h0, q}, 8'h00);
    tick(); check("R6 wrap down to max", {4'h0, q}, 8'h0F);
    tick(); check("R4 down after wrap", {4'h0, q}, 8'h0E);
    en_n = 1'b1;
  endtask

  task automatic t_hold();
    tick();
    preset(4'h7);
    for (int i = 0; i < 4; i++) begin
      up = i[0];
      tick();
      check("R5 hold while disabled", {4'h0, q}, 8'h07);
    end
    check("R7 flag high mid range", {7'h0, tc_n}, 8'h01);
  endtask

  task automatic t_term();
    tick();
    en_n = 1'b1;
    preset(4'hF);
    up = 1'b1; en_n = 1'b0; #0.5;
    check("R7 flag low at max counting up", {7'h0, tc_n}, 8'h00);
    en_n = 1'b1; #0.5;
    check("R8 flag follows enable", {7'h0, tc_n}, 8'h01);
    tick();
    up = 1'b0; en_n = 1'b0; #0.5;
    check("R8 flag follows direction at max", {7'h0, tc_n}, 8'h01);
    en_n = 1'b1;
    preset(4'h0);
    en_n = 1'b0; #0.5;
    check("R7 flag low at zero counting down", {7'h0, tc_n}, 8'h00);
    up = 1'b1; #0.5;
    check("R8 flag follows direction at zero", {7'h0, tc_n}, 8'h01);
    en_n = 1'b1;
  endtask

  task automatic t_midperiod();
    tick();
    preset(4'h4);
    tick();
    up = 1'b1; en_n = 1'b0;
    tick(); check("R3 count before pulses", {4'h0, q}, 8'h05);
    #1 ld = 1'b1; din = 4'hA; #0.3;
    check("R2 mid-period preset", {4'h0, q}, 8'h0A);
    ld = 1'b0; #0.4;
    check("R9 preset pulse value kept", {4'h0, q}, 8'h0A);
    tick(); check("R9 count after preset pulse", {4'h0, q}, 8'h0B);
    #1 rst = 1'b1; #0.3;
    check("R1 mid-period clear", {4'h0, q}, 8'h00);
    rst = 1'b0; #0.4;
    check("R1 clear pulse result kept", {4'h0, q}, 8'h00);
    tick(); check("R9 count after clear pulse", {4'h0, q}, 8'h01);
    ld = 1'b1; din = 4'h6; #0.4;
    check("R2 preset during count", {4'h0, q}, 8'h06);
    rst = 1'b1; #0.4;
    check("R1 clear while preset high", {4'h0, q}, 8'h00);
    rst = 1'b0; #0.4;
    check("R9 clear released under preset", {4'h0, q}, 8'h06);
    ld = 1'b0; en_n = 1'b1; #0.4;
    check("R9 preset released", {4'h0, q}, 8'h06);
    tick(); check("R5 hold after pulses", {4'h0, q}, 8'h06);
  endtask

  task automatic t_cascade();
    logic [7:0] starts [3] = '{8'hFD, 8'h0E, 8'h02};
    logic       dirs   [3] = '{1'b1, 1'b1, 1'b0};
    tick();
    c_rst = 1'b0;
    for (int s = 0; s < 3; s++) begin
      logic [7:0] exp;
      tick();
      c_en_n = 1'b1;
      c_ld = 1'b1; c_din = starts[s]; #0.4;
      c_ld = 1'b0; #0.4;
      check("R10 chain preset", {c_hi, c_lo}, starts[s]);
      exp = starts[s];
      c_up = dirs[s]; c_en_n = 1'b0;
      for (int k = 0; k < 5; k++) begin
        tick();
        exp = dirs[s] ? exp + 8'd1 : exp - 8'd1;
        check("R10 chained step", {c_hi, c_lo}, exp);
      end
      c_en_n = 1'b1;
    end
  endtask

  initial begin
    t_reset();
    t_load();
    t_count_up();
    t_count_down();
    t_hold();
    t_term();
    t_midperiod();
    t_cascade();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule